// File: doc/BRIEF.md
# USB Endpoint Transaction Responder

This block sits at the transaction layer of a full-speed USB device. The packet layer below it decodes a token (SETUP, IN or OUT) and passes it in with an endpoint number. The responder then looks up a per-endpoint configuration word and two buffer descriptors. On the next clock it returns the handshake to send: ACK, NAK, STALL, or silence. It also reports which descriptor it picked. When the ACKed data phase ends well, the packet layer pulses a success input. The responder then marks the chosen descriptor done, flips the ping-pong bit where one applies, and queues a completion event for firmware.

Each endpoint has one of four buffer modes: off, single, ping-pong, or control split. In control split mode, descriptor 1 takes only SETUP data and descriptor 0 takes every other transaction. A control endpoint can also be locked out. When the lockout is enabled, any SETUP received on a control endpoint sets a lock flag. While that flag is set, all IN and OUT traffic to control endpoints is NAKed, so firmware can parse the SETUP before stale buffers are used. Only a firmware write clears the flag. Firmware owns the descriptor contents, including the data address, and reaches them through a simple word-wide register port. Completions can also be found by polling the descriptor done bits.

Top module: `usb_xact_responder`

## Requirements
- R1: After reset, hs_valid and evt_valid are low, and every register reads zero: endpoint words, descriptors, and the global word.
- R2: The handshake appears in the cycle after tok_valid, with code 0 for silence, 1 for ACK, 2 for NAK and 3 for STALL. Token codes are 1 for OUT, 2 for IN and 3 for SETUP. An endpoint whose mode field (bits 1:0 of its word) is 0 stays silent. Otherwise, an IN or OUT is ACKed only if the selected descriptor has rdy (bit 0) set, done (bit 1) clear, and dir (bit 2, 1 for IN) matching the token. In every other case it is NAKed.
- R3: In single mode (mode 1), descriptor 0 is always used. A successful transfer clears rdy and sets done, so a repeat token is NAKed until firmware rearms the descriptor.
- R4: In ping-pong mode (mode 2), the toggle bit (bit 4 of the endpoint word) selects the descriptor and is inverted by each successful transfer.
- R5: When the halt bit (bit 3) is set, IN and OUT are answered with STALL. A SETUP on a halted control endpoint is still handled by the buffer rules.
- R6: A SETUP on an endpoint whose control bit (bit 2) is clear gets silence, and it creates no pending transfer.
- R7: When lockout is enabled (global bit 0), a SETUP on an enabled control endpoint sets the lock flag (global bit 1), whether the SETUP is ACKed or NAKed. While the flag is set, IN and OUT on control endpoints are NAKed even with a ready descriptor. Non-control endpoints are not affected. With lockout disabled, no flag is set.
- R8: Only a global write with bit 1 set clears the lock flag. Tokens and other writes leave it set.
- R9: In control split mode (mode 3), a SETUP uses descriptor 1 and an IN or OUT uses descriptor 0, and the toggle bit does not change.
- R10: Each successful transfer queues an event {ep, in, setup, desc}, with desc in bit 0, setup in bit 1, in in bit 2, and ep in the upper bits. Events leave in arrival order, one per evt_pop.
- R11: When the event queue is full, further events are dropped. The descriptor is still marked done, and the queued events are kept intact.
- R12: A failure pulse, or no success pulse, after an ACK leaves the descriptor, the toggle bit and the queue unchanged.
- R13: Descriptor data addresses (bits above dir) are stored exactly as written, and no overlap check is made, so two descriptors may hold the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_pid | input | 2 | Token kind: 1 OUT, 2 IN, 3 SETUP |
| tok_ep | input | EP_W | Endpoint number of the token |
| xfer_ok | input | 1 | Data phase of the last ACKed token completed |
| xfer_fail | input | 1 | Data phase of the last ACKed token aborted |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 silent, 1 ACK, 2 NAK, 3 STALL |
| hs_desc | output | 1 | Descriptor index selected for the token |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | EP_W+2 | {endpoint, slot}: slot 0 config, 1 and 2 descriptors, 3 global |
| reg_wdata | input | ADDR_W+3 | Register write data |
| reg_rdata | output | ADDR_W+3 | Register read data at reg_addr |
| evt_pop | input | 1 | Remove the head event |
| evt_valid | output | 1 | Event queue not empty |
| evt_data | output | EP_W+3 | Head event {ep, in, setup, desc} |

## Verification
The bench builds the responder with four endpoints, 11-bit data addresses and an event queue only two entries deep. Four endpoints let a single run keep a control endpoint, a single-buffered one, a ping-pong one and a disabled one configured at the same time, so checks for cross-endpoint effects such as the lock flag can be made directly. The two-entry queue means three unpopped completions are enough to reach the drop-when-full behaviour and check that the queued order survives it.

// File: rtl/usb_xact_pkg.sv
// Shared types for the endpoint transaction responder.
// Assumes: encodings below are visible to firmware and the packet layer.
package usb_xact_pkg;

    typedef enum logic [1:0] {
        TOK_NONE  = 2'd0,
        TOK_OUT   = 2'd1,
        TOK_IN    = 2'd2,
        TOK_SETUP = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_SILENT = 2'd0,
        HS_ACK    = 2'd1,
        HS_NAK    = 2'd2,
        HS_STALL  = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        BM_OFF        = 2'd0,
        BM_SINGLE     = 2'd1,
        BM_PINGPONG   = 2'd2,
        BM_CTRL_SPLIT = 2'd3
    } bufmode_e;

    // Endpoint word: toggle[4] halt[3] ctrl[2] mode[1:0]
    typedef struct packed {
        logic     toggle;
        logic     halt;
        logic     ctrl;
        bufmode_e mode;
    } ep_cfg_t;

    // Descriptor flag bits: dir_in[2] done[1] rdy[0]
    typedef struct packed {
        logic dir_in;
        logic done;
        logic rdy;
    } desc_flags_t;

    localparam int CFG_W   = 5;
    localparam int FLAGS_W = 3;

    localparam logic [1:0] SLOT_CFG    = 2'd0;
    localparam logic [1:0] SLOT_D0     = 2'd1;
    localparam logic [1:0] SLOT_D1     = 2'd2;
    localparam logic [1:0] SLOT_GLOBAL = 2'd3;

endpackage

// File: rtl/xact_evt_fifo.sv
// Completion event queue.
// Does: stores DEPTH events of W bits; a push while full is dropped.
// Assumes: DEPTH >= 2; a pop while empty is ignored.
module xact_evt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_ptr];

    // Purpose: write an accepted event into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Purpose: advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R11
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> cnt == $past(cnt)); // R11

endmodule

// File: rtl/xact_ep_table.sv
// Endpoint configuration and descriptor table with register port.
// Does: holds per-endpoint words, two descriptors per endpoint, and the
//       lockout enable and flag; applies completions from the decider.
// Assumes: a firmware write to the same word in the completion cycle wins.
module xact_ep_table
    import usb_xact_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2,
    parameter int ADDR_W = 11,
    parameter int REG_W  = ADDR_W + 3,
    parameter int RA_W   = EP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              comp_vld,
    input  logic [EP_W-1:0]   comp_ep,
    input  logic              comp_desc,
    input  logic              lock_set,
    output ep_cfg_t           cfg    [NUM_EP],
    output desc_flags_t       flags0 [NUM_EP],
    output desc_flags_t       flags1 [NUM_EP],
    output logic              lock_q,
    output logic              lock_en
);
    ep_cfg_t            cfg_q  [NUM_EP];
    desc_flags_t        fl_q   [NUM_EP][2];
    logic [ADDR_W-1:0]  addr_q [NUM_EP][2];
    logic [EP_W-1:0]    a_ep;
    logic [1:0]         a_slot;
    logic               gl_wr;
    logic               lock_en_q;
    logic               lock_flag_q;

    assign a_ep   = reg_addr[RA_W-1:2];
    assign a_slot = reg_addr[1:0];
    assign gl_wr  = reg_wr && (a_slot == SLOT_GLOBAL);

    // Purpose: apply completions, then firmware writes, to the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_EP; i++) begin
                cfg_q[i] <= '0;
                for (int j = 0; j < 2; j++) begin
                    fl_q[i][j]   <= '0;
                    addr_q[i][j] <= '0;
                end
            end
        end else begin
            if (comp_vld) begin
                fl_q[comp_ep][comp_desc].rdy  <= 1'b0;
                fl_q[comp_ep][comp_desc].done <= 1'b1;
                if (cfg_q[comp_ep].mode == BM_PINGPONG) begin
                    cfg_q[comp_ep].toggle <= ~cfg_q[comp_ep].toggle;
                end
            end
            if (reg_wr) begin
                case (a_slot)
                    SLOT_CFG: cfg_q[a_ep] <= ep_cfg_t'(reg_wdata[CFG_W-1:0]);
                    SLOT_D0: begin
                        fl_q[a_ep][0]   <= desc_flags_t'(reg_wdata[FLAGS_W-1:0]);
                        addr_q[a_ep][0] <= reg_wdata[REG_W-1:FLAGS_W];
                    end
                    SLOT_D1: begin
                        fl_q[a_ep][1]   <= desc_flags_t'(reg_wdata[FLAGS_W-1:0]);
                        addr_q[a_ep][1] <= reg_wdata[REG_W-1:FLAGS_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: lockout enable bit and the sticky lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_en_q   <= 1'b0;
            lock_flag_q <= 1'b0;
        end else begin
            if (gl_wr) begin
                lock_en_q <= reg_wdata[0];
            end
            if (lock_set) begin
                lock_flag_q <= 1'b1;
            end else if (gl_wr && reg_wdata[1]) begin
                lock_flag_q <= 1'b0;
            end
        end
    end

    // Purpose: read mux for the register port.
    always_comb begin
        reg_rdata = '0;
        case (a_slot)
            SLOT_CFG: reg_rdata[CFG_W-1:0] = cfg_q[a_ep];
            SLOT_D0:  reg_rdata = {addr_q[a_ep][0], fl_q[a_ep][0]};
            SLOT_D1:  reg_rdata = {addr_q[a_ep][1], fl_q[a_ep][1]};
            default:  reg_rdata[1:0] = {lock_flag_q, lock_en_q};
        endcase
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_out
        assign cfg[g]    = cfg_q[g];
        assign flags0[g] = fl_q[g][0];
        assign flags1[g] = fl_q[g][1];
    end

    assign lock_q  = lock_flag_q;
    assign lock_en = lock_en_q;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag_q && !(gl_wr && reg_wdata[1]) |=> lock_flag_q); // R8

endmodule

// File: rtl/xact_decider.sv
// Handshake decision and pending-transfer tracking.
// Does: picks a descriptor for each token, decides the handshake one cycle
//       later, remembers an ACKed transfer until success or failure.
// Assumes: NUM_EP is a power of two; at most one transfer outstanding, a
//          new token abandons any older pending one.
module xact_decider
    import usb_xact_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              xfer_ok,
    input  logic              xfer_fail,
    input  ep_cfg_t           cfg    [NUM_EP],
    input  desc_flags_t       flags0 [NUM_EP],
    input  desc_flags_t       flags1 [NUM_EP],
    input  logic              lock_q,
    input  logic              lock_en,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              hs_desc,
    output logic              lock_set,
    output logic              comp_vld,
    output logic [EP_W-1:0]   comp_ep,
    output logic              comp_desc,
    output logic              comp_in,
    output logic              comp_setup
);
    tok_e            pid;
    ep_cfg_t         c;
    desc_flags_t     fsel;
    logic            sel_desc;
    logic            buf_ok;
    hs_e             code;

    logic            hs_valid_q;
    hs_e             hs_code_q;
    logic            hs_desc_q;
    logic            pend_vld;
    logic [EP_W-1:0] pend_ep;
    logic            pend_desc;
    logic            pend_in;
    logic            pend_setup;

    assign pid = tok_e'(tok_pid);

    // Purpose: select the descriptor and decide the handshake for the token.
    always_comb begin
        c = cfg[tok_ep];
        case (c.mode)
            BM_PINGPONG:   sel_desc = c.toggle;
            BM_CTRL_SPLIT: sel_desc = (pid == TOK_SETUP);
            default:       sel_desc = 1'b0;
        endcase
        fsel   = sel_desc ? flags1[tok_ep] : flags0[tok_ep];
        buf_ok = fsel.rdy && !fsel.done && (fsel.dir_in == (pid == TOK_IN));
        code   = HS_SILENT;
        if (c.mode != BM_OFF) begin
            case (pid)
                TOK_SETUP: begin
                    if (c.ctrl) begin
                        code = buf_ok ? HS_ACK : HS_NAK;
                    end
                end
                TOK_IN, TOK_OUT: begin
                    if (c.halt) begin
                        code = HS_STALL;
                    end else if (c.ctrl && lock_q) begin
                        code = HS_NAK;
                    end else begin
                        code = buf_ok ? HS_ACK : HS_NAK;
                    end
                end
                default: code = HS_SILENT;
            endcase
        end
    end

    assign lock_set = tok_valid && (pid == TOK_SETUP) && (c.mode != BM_OFF)
                      && c.ctrl && lock_en;

    // Purpose: register the handshake decision for the packet layer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_SILENT;
            hs_desc_q  <= 1'b0;
        end else begin
            hs_valid_q <= tok_valid;
            if (tok_valid) begin
                hs_code_q <= code;
                hs_desc_q <= sel_desc;
            end
        end
    end

    // Purpose: hold the ACKed transfer until its data phase resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld   <= 1'b0;
            pend_ep    <= '0;
            pend_desc  <= 1'b0;
            pend_in    <= 1'b0;
            pend_setup <= 1'b0;
        end else if (tok_valid) begin
            pend_vld   <= (code == HS_ACK);
            pend_ep    <= tok_ep;
            pend_desc  <= sel_desc;
            pend_in    <= (pid == TOK_IN);
            pend_setup <= (pid == TOK_SETUP);
        end else if (xfer_ok || xfer_fail) begin
            pend_vld <= 1'b0;
        end
    end

    assign comp_vld   = pend_vld && xfer_ok;
    assign comp_ep    = pend_ep;
    assign comp_desc  = pend_desc;
    assign comp_in    = pend_in;
    assign comp_setup = pend_setup;

    assign hs_valid = hs_valid_q;
    assign hs_code  = hs_code_q;
    assign hs_desc  = hs_desc_q;

    AST_HALT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid_q && $past(c.mode != BM_OFF && c.halt
                            && (pid == TOK_IN || pid == TOK_OUT))
        |-> hs_code_q == HS_STALL); // R5
    AST_LOCK_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid_q && $past(lock_q && c.ctrl && c.mode != BM_OFF && !c.halt
                            && (pid == TOK_IN || pid == TOK_OUT))
        |-> hs_code_q == HS_NAK); // R7
    AST_SETUP_NONCTRL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid_q && $past(pid == TOK_SETUP && !c.ctrl)
        |-> hs_code_q == HS_SILENT); // R6

endmodule

// File: rtl/usb_xact_responder.sv
// Top of the endpoint transaction responder.
// Does: ties the decider, the endpoint table and the event queue together.
// Assumes: tokens and data-phase results come from a packet layer in the
//          same clock domain; firmware uses the register port.
module usb_xact_responder
    import usb_xact_pkg::*;
#(
    parameter int NUM_EP     = 4,
    parameter int ADDR_W     = 11,
    parameter int FIFO_DEPTH = 4,
    localparam int EP_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int RA_W      = EP_W + 2,
    localparam int REG_W     = ADDR_W + 3,
    localparam int EVT_W     = EP_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              xfer_ok,
    input  logic              xfer_fail,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              hs_desc,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              evt_pop,
    output logic              evt_valid,
    output logic [EVT_W-1:0]  evt_data
);
    ep_cfg_t         cfg    [NUM_EP];
    desc_flags_t     flags0 [NUM_EP];
    desc_flags_t     flags1 [NUM_EP];
    logic            lock_q;
    logic            lock_en;
    logic            lock_set;
    logic            comp_vld;
    logic [EP_W-1:0] comp_ep;
    logic            comp_desc;
    logic            comp_in;
    logic            comp_setup;

    xact_decider #(
        .NUM_EP (NUM_EP),
        .EP_W   (EP_W)
    ) i_decider (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_pid    (tok_pid),
        .tok_ep     (tok_ep),
        .xfer_ok    (xfer_ok),
        .xfer_fail  (xfer_fail),
        .cfg        (cfg),
        .flags0     (flags0),
        .flags1     (flags1),
        .lock_q     (lock_q),
        .lock_en    (lock_en),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code),
        .hs_desc    (hs_desc),
        .lock_set   (lock_set),
        .comp_vld   (comp_vld),
        .comp_ep    (comp_ep),
        .comp_desc  (comp_desc),
        .comp_in    (comp_in),
        .comp_setup (comp_setup)
    );

    xact_ep_table #(
        .NUM_EP (NUM_EP),
        .EP_W   (EP_W),
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .RA_W   (RA_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .comp_vld  (comp_vld),
        .comp_ep   (comp_ep),
        .comp_desc (comp_desc),
        .lock_set  (lock_set),
        .cfg       (cfg),
        .flags0    (flags0),
        .flags1    (flags1),
        .lock_q    (lock_q),
        .lock_en   (lock_en)
    );

    xact_evt_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (EVT_W)
    ) i_evt_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (comp_vld),
        .din   ({comp_ep, comp_in, comp_setup, comp_desc}),
        .pop   (evt_pop),
        .valid (evt_valid),
        .dout  (evt_data)
    );

endmodule

// File: tb/test_usb_xact_responder.sv
// Directed bench for the endpoint transaction responder.
module test_usb_xact_responder;
    localparam int NUM_EP = 4;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 2;
    localparam int SIL = 0, ACK = 1, NAK = 2, STALL = 3;
    localparam logic [1:0] P_OUT = 2'd1, P_IN = 2'd2, P_SETUP = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_pid = '0;
    logic [1:0]  tok_ep = '0;
    logic        xfer_ok = 1'b0;
    logic        xfer_fail = 1'b0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        hs_desc;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [13:0] reg_wdata = '0;
    logic [13:0] reg_rdata;
    logic        evt_pop = 1'b0;
    logic        evt_valid;
    logic [4:0]  evt_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_xact_responder #(
        .NUM_EP     (NUM_EP),
        .ADDR_W     (ADDR_W),
        .FIFO_DEPTH (DEPTH)
    ) i_usb_xact_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_pid   (tok_pid),
        .tok_ep    (tok_ep),
        .xfer_ok   (xfer_ok),
        .xfer_fail (xfer_fail),
        .hs_valid  (hs_valid),
        .hs_code   (hs_code),
        .hs_desc   (hs_desc),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pop   (evt_pop),
        .evt_valid (evt_valid),
        .evt_data  (evt_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ra(input int ep, input int slot);
        return 4'(ep * 4 + slot);
    endfunction

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = 14'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic tok(input logic [1:0] pid, input int ep, input int exp_code,
                       input int exp_desc, input string req);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = pid; tok_ep = 2'(ep);
        @(negedge clk);
        tok_valid = 1'b0; tok_pid = '0;
        check(req, int'(hs_valid), 1);
        check(req, int'(hs_code), exp_code);
        if (exp_code == ACK) check(req, int'(hs_desc), exp_desc);
    endtask

    task automatic ok_pulse();
        @(negedge clk); xfer_ok = 1'b1;
        @(negedge clk); xfer_ok = 1'b0;
    endtask

    task automatic fail_pulse();
        @(negedge clk); xfer_fail = 1'b1;
        @(negedge clk); xfer_fail = 1'b0;
    endtask

    task automatic pop_check(input int exp, input string req);
        @(negedge clk);
        check(req, int'(evt_valid), 1);
        check(req, int'(evt_data), exp);
        evt_pop = 1'b1;
        @(negedge clk);
        evt_pop = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 hs_valid", int'(hs_valid), 0);
        check("R1 evt_valid", int'(evt_valid), 0);
        for (int s = 0; s < 4; s++) rd_check(ra(0, s), 0, "R1 ep0 reg");
        rd_check(ra(3, 1), 0, "R1 ep3 desc0");
    endtask

    task automatic t_single();
        wr(ra(1, 0), 1);
        tok(P_IN, 1, NAK, 0, "R2 not ready");
        wr(ra(1, 1), 'h101);
        tok(P_IN, 1, NAK, 0, "R2 dir mismatch");
        tok(P_OUT, 1, ACK, 0, "R2 ready OUT");
        ok_pulse();
        rd_check(ra(1, 1), 'h102, "R3 done set rdy clear");
        pop_check(8, "R10 single event");
        tok(P_OUT, 1, NAK, 0, "R3 repeat NAK");
        tok(P_OUT, 3, SIL, 0, "R2 disabled ep silent");
    endtask

    task automatic t_double();
        wr(ra(2, 0), 2);
        wr(ra(2, 1), 13);
        wr(ra(2, 2), 21);
        tok(P_IN, 2, ACK, 0, "R4 toggle0 desc0");
        ok_pulse();
        rd_check(ra(2, 0), 'h12, "R4 toggle flipped");
        tok(P_IN, 2, ACK, 1, "R4 toggle1 desc1");
        ok_pulse();
        rd_check(ra(2, 0), 'h02, "R4 toggle back");
        pop_check(20, "R10 first pingpong event");
        pop_check(21, "R10 second pingpong event");
        wr(ra(2, 1), 13);
        tok(P_IN, 2, ACK, 0, "R12 pingpong ack");
        fail_pulse();
        rd_check(ra(2, 0), 'h02, "R12 toggle kept");
        rd_check(ra(2, 1), 13, "R12 desc kept");
        wr(ra(2, 1), 61);
        wr(ra(2, 2), 61);
        rd_check(ra(2, 1), 61, "R13 same addr d0");
        rd_check(ra(2, 2), 61, "R13 same addr d1");
    endtask

    task automatic t_fail();
        wr(ra(1, 1), 'h101);
        tok(P_OUT, 1, ACK, 0, "R12 ack");
        fail_pulse();
        rd_check(ra(1, 1), 'h101, "R12 desc unchanged");
        check("R12 no event", int'(evt_valid), 0);
        tok(P_OUT, 1, ACK, 0, "R12 retry ack");
        ok_pulse();
        pop_check(8, "R10 retry event");
    endtask

    task automatic t_halt();
        wr(ra(1, 0), 9);
        wr(ra(1, 1), 'h101);
        tok(P_OUT, 1, STALL, 0, "R5 OUT stall");
        tok(P_IN, 1, STALL, 0, "R5 IN stall");
        wr(ra(0, 0), 13);
        wr(ra(0, 1), 1);
        tok(P_SETUP, 0, ACK, 0, "R5 setup on halted ctrl");
        fail_pulse();
    endtask

    task automatic t_setup_nonctrl();
        wr(ra(1, 0), 1);
        wr(ra(1, 1), 'h101);
        tok(P_SETUP, 1, SIL, 0, "R6 setup non-ctrl");
        ok_pulse();
        check("R6 no event", int'(evt_valid), 0);
        rd_check(ra(1, 1), 'h101, "R6 desc untouched");
    endtask

    task automatic t_lockout();
        wr(ra(0, 3), 1);
        wr(ra(0, 0), 5);
        wr(ra(0, 1), 1);
        tok(P_SETUP, 0, ACK, 0, "R7 setup ack");
        ok_pulse();
        pop_check(2, "R10 setup event");
        rd_check(ra(0, 3), 3, "R7 lock set");
        wr(ra(0, 1), 5);
        tok(P_IN, 0, NAK, 0, "R7 locked IN nak");
        wr(ra(1, 1), 'h101);
        tok(P_OUT, 1, ACK, 0, "R7 non-ctrl unaffected");
        fail_pulse();
        rd_check(ra(0, 3), 3, "R8 tokens keep lock");
        wr(ra(2, 3), 1);
        rd_check(ra(0, 3), 3, "R8 write without clear");
        wr(ra(0, 3), 3);
        rd_check(ra(0, 3), 1, "R8 clear write");
        tok(P_IN, 0, ACK, 0, "R8 unlocked IN ack");
        fail_pulse();
        wr(ra(0, 3), 0);
        tok(P_SETUP, 0, NAK, 0, "R7 setup nak");
        rd_check(ra(0, 3), 0, "R7 disabled no lock");
        wr(ra(0, 3), 1);
        tok(P_SETUP, 0, NAK, 0, "R7 setup nak enabled");
        rd_check(ra(0, 3), 3, "R7 nak setup locks");
        wr(ra(0, 3), 2);
        rd_check(ra(0, 3), 0, "R8 clear and disable");
    endtask

    task automatic t_ctrl_split();
        wr(ra(0, 0), 7);
        wr(ra(0, 1), 25);
        wr(ra(0, 2), 33);
        tok(P_OUT, 0, ACK, 0, "R9 OUT desc0");
        ok_pulse();
        tok(P_SETUP, 0, ACK, 1, "R9 SETUP desc1");
        ok_pulse();
        rd_check(ra(0, 0), 7, "R9 toggle unchanged");
        rd_check(ra(0, 1), 26, "R9 desc0 done");
        rd_check(ra(0, 2), 34, "R9 desc1 done");
        pop_check(0, "R10 split OUT event");
        pop_check(3, "R10 split SETUP event");
        wr(ra(0, 1), 5);
        tok(P_IN, 0, ACK, 0, "R9 IN desc0");
        fail_pulse();
    endtask

    task automatic t_overflow();
        wr(ra(1, 0), 1);
        wr(ra(1, 1), 'h101);
        tok(P_OUT, 1, ACK, 0, "R11 fill 1");
        ok_pulse();
        wr(ra(1, 1), 'h10D);
        tok(P_IN, 1, ACK, 0, "R11 fill 2");
        ok_pulse();
        wr(ra(1, 1), 'h101);
        tok(P_OUT, 1, ACK, 0, "R11 over");
        ok_pulse();
        rd_check(ra(1, 1), 'h102, "R11 desc done while full");
        pop_check(8, "R11 order first");
        pop_check(12, "R11 order second");
        @(negedge clk);
        check("R11 dropped event", int'(evt_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_double();
        t_fail();
        t_halt();
        t_setup_nonctrl();
        t_lockout();
        t_ctrl_split();
        t_overflow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule